// File: doc/BRIEF.md
# Interrupt Level Recognizer

This block sits beside a processor core and decides, once per instruction, whether the core should leave its normal flow to service an interrupt. An external interrupt controller presents a 3-bit encoded request level. Level 0 means no request, 1 is the lowest priority and 7 is the highest. The core presents a strobe on each instruction boundary. The block also owns the 3-bit interrupt mask, which software loads through writes to the status word.

Levels 1 to 6 are level-sensitive and maskable. They are serviced only if they are still present at the boundary and exceed the current mask. Level 7 cannot be masked. It acts on its rising transition: a change of the request from any lower level to 7 is remembered until the next boundary and serviced there once, however long the request then stays at 7.

When a request is serviced, the block emits a one-cycle take pulse carrying the serviced level. On the same edge it raises the mask to that level, so equal or lower requests are held off until software lowers the mask again.

Top module: `irq_level_recognizer`

## Requirements
- R1: During and after reset the mask reads 7, the take pulse is low with level 0, and any remembered level-7 transition is discarded.
- R2: No request is serviced in a cycle without the boundary strobe.
- R3: A request of level 1 to 6 is serviced at a strobe only when it is strictly greater than the mask. In that case take_o is high in the following cycle and take_level_o carries the level; otherwise take_level_o reads 0.
- R4: When a request is serviced, the mask is loaded with the serviced level on the same edge as the take pulse.
- R5: A change of the request from below 7 to 7 is remembered and serviced as level 7 at the next strobe, even when the mask is 7.
- R6: A request that stays at 7 is not serviced again after its transition has been serviced.
- R7: A level 1 to 6 request that goes away before the strobe is not serviced.
- R8: A status write with sr_we_i loads the mask from bits 10:8 of sr_wdata_i. The write has no effect in a cycle where a request is serviced.
- R9: A remembered level-7 transition survives strobe-free cycles and a return of the request to a lower level.
- R10: Coming out of reset, a request already at 7 counts as a new transition, because the previous level is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_level_i | input | 3 | Encoded request level from the interrupt controller |
| boundary_i | input | 1 | Instruction-boundary strobe |
| sr_we_i | input | 1 | Status word write enable |
| sr_wdata_i | input | 16 | Status word write data; the mask is in bits 10:8 |
| mask_o | output | 3 | Current interrupt mask |
| take_o | output | 1 | One-cycle interrupt take pulse |
| take_level_o | output | 3 | Serviced level while take_o is high, else 0 |

## Verification
The hardest situation to reach is a remembered level-7 transition that must cross several boundary-free cycles and then be serviced after the request has already fallen back, or while it still holds at 7 under a mask of 7. Uniform random levels rarely produce this. The stimulus therefore keeps each level sticky over many cycles and keeps the strobe sparse, so transitions to 7 often occur between strobes. Directed sequences then build the fallback, the held-7 case and a transition just before reset on purpose.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
   localparam int unsigned LVL_W_DEFAULT = 3;
   localparam int unsigned SR_W_DEFAULT  = 16;
   localparam int unsigned MASK_LSB_DEFAULT = 8;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_LEVEL = 2'd1,
      SRC_EDGE  = 2'd2
   } take_src_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int unsigned LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             clr_i,
   output logic             pend_o
);
   localparam logic [LVL_W-1:0] TOP_LVL = '1;

   logic [LVL_W-1:0] prev_q;
   logic             held_q;
   logic             rise;

   assign rise   = (lvl_i == TOP_LVL) && (prev_q != TOP_LVL);
   assign pend_o = held_q | rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         held_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         held_q <= pend_o & ~clr_i;
      end
   end
endmodule

// File: rtl/irq_level_judge.sv
module irq_level_judge
   import irq_rec_pkg::*;
#(
   parameter int unsigned LVL_W = 3
) (
   input  logic             strobe_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0] mask_i,
   input  logic             edge_pend_i,
   output logic             take_o,
   output logic [LVL_W-1:0] svc_lvl_o,
   output take_src_e        src_o
);
   localparam logic [LVL_W-1:0] TOP_LVL = '1;

   logic maskable_req;
   assign maskable_req = (lvl_i != '0) && (lvl_i != TOP_LVL) && (lvl_i > mask_i);

   always_comb begin
      src_o     = SRC_NONE;
      svc_lvl_o = '0;
      if (strobe_i) begin
         if (edge_pend_i) begin
            src_o     = SRC_EDGE;
            svc_lvl_o = TOP_LVL;
         end else if (maskable_req) begin
            src_o     = SRC_LEVEL;
            svc_lvl_o = lvl_i;
         end
      end
      take_o = (src_o != SRC_NONE);
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned LVL_W    = 3,
   parameter int unsigned SR_W     = 16,
   parameter int unsigned MASK_LSB = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [SR_W-1:0]  wdata_i,
   input  logic             take_i,
   input  logic [LVL_W-1:0] svc_lvl_i,
   output logic [LVL_W-1:0] mask_o
);
   logic [LVL_W-1:0] field;

   generate
      if (SR_W == LVL_W) begin : g_whole
         assign field = wdata_i;
      end else begin : g_slice
         logic [SR_W-1:0] shifted;
         assign shifted = wdata_i >> MASK_LSB;
         assign field   = shifted[LVL_W-1:0];
         logic unused_hi;
         assign unused_hi = ^shifted[SR_W-1:LVL_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      mask_o <= '1;
      else if (take_i) mask_o <= svc_lvl_i;
      else if (wr_i)   mask_o <= field;
   end
endmodule

// File: rtl/irq_level_recognizer.sv
module irq_level_recognizer
   import irq_rec_pkg::*;
#(
   parameter int unsigned LVL_W    = LVL_W_DEFAULT,
   parameter int unsigned SR_W     = SR_W_DEFAULT,
   parameter int unsigned MASK_LSB = MASK_LSB_DEFAULT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] req_level_i,
   input  logic             boundary_i,
   input  logic             sr_we_i,
   input  logic [SR_W-1:0]  sr_wdata_i,
   output logic [LVL_W-1:0] mask_o,
   output logic             take_o,
   output logic [LVL_W-1:0] take_level_o
);
   generate
      if (LVL_W < 2) begin : g_bad_w
         $error("LVL_W must be at least 2");
      end
      if (MASK_LSB + LVL_W > SR_W) begin : g_bad_pos
         $error("mask field does not fit in the status word");
      end
   endgenerate

   logic             edge_pend;
   logic             take_now;
   logic [LVL_W-1:0] svc_lvl;
   take_src_e        src;

   irq_edge_latch #(.LVL_W(LVL_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(req_level_i),
      .clr_i(take_now), .pend_o(edge_pend)
   );

   irq_level_judge #(.LVL_W(LVL_W)) u_judge (
      .strobe_i(boundary_i), .lvl_i(req_level_i), .mask_i(mask_o),
      .edge_pend_i(edge_pend), .take_o(take_now), .svc_lvl_o(svc_lvl),
      .src_o(src)
   );

   irq_mask_reg #(.LVL_W(LVL_W), .SR_W(SR_W), .MASK_LSB(MASK_LSB)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_i(sr_we_i), .wdata_i(sr_wdata_i),
      .take_i(take_now), .svc_lvl_i(svc_lvl), .mask_o(mask_o)
   );

   logic unused_src;
   assign unused_src = ^src;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_o       <= 1'b0;
         take_level_o <= '0;
      end else begin
         take_o       <= take_now;
         take_level_o <= svc_lvl;
      end
   end
endmodule

// File: rtl/irq_level_recognizer_chk.sv
module irq_level_recognizer_chk #(
   parameter int unsigned LVL_W = 3,
   parameter int unsigned SR_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] req_level_i,
   input logic             boundary_i,
   input logic             sr_we_i,
   input logic [SR_W-1:0]  sr_wdata_i,
   input logic [LVL_W-1:0] mask_o,
   input logic             take_o,
   input logic [LVL_W-1:0] take_level_o
);
   localparam logic [LVL_W-1:0] TOP_LVL = '1;

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (mask_o == TOP_LVL) && !take_o && (take_level_o == '0));

   assert_strobe_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary_i |=> !take_o);

   assert_idle_level_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> take_level_o == '0);

   assert_above_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && req_level_i != TOP_LVL && req_level_i != '0 && req_level_i <= mask_o)
      |=> (!take_o || take_level_o == TOP_LVL));

   assert_mask_follows_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> mask_o == take_level_o);

   assert_mask_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_we_i && !boundary_i) |=> $stable(mask_o));

   logic unused_wd;
   assign unused_wd = ^sr_wdata_i;
endmodule

bind irq_level_recognizer irq_level_recognizer_chk #(.LVL_W(LVL_W), .SR_W(SR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_level_i(req_level_i), .boundary_i(boundary_i),
   .sr_we_i(sr_we_i), .sr_wdata_i(sr_wdata_i), .mask_o(mask_o),
   .take_o(take_o), .take_level_o(take_level_o)
);

// File: tb/irq_level_recognizer_tb.sv
module irq_level_recognizer_tb;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  req_level_i = '0;
   logic        boundary_i = 1'b0;
   logic        sr_we_i = 1'b0;
   logic [15:0] sr_wdata_i = '0;
   logic [2:0]  mask_o;
   logic        take_o;
   logic [2:0]  take_level_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [2:0] m_prev, m_mask, e_lvl;
   logic       m_lat, e_take;

   irq_level_recognizer u_dut (
      .clk(clk), .rst_n(rst_n), .req_level_i(req_level_i), .boundary_i(boundary_i),
      .sr_we_i(sr_we_i), .sr_wdata_i(sr_wdata_i), .mask_o(mask_o),
      .take_o(take_o), .take_level_o(take_level_o)
   );

   always #(PERIOD/2) clk = ~clk;

   function automatic logic [15:0] sr_word(input logic [2:0] m);
      return (16'($urandom) & 16'hF8FF) | (16'(m) << 8);
   endfunction

   task automatic model_step();
      logic edge_now, pend, take;
      logic [2:0] svc;
      if (!rst_n) begin
         m_prev = '0; m_lat = 1'b0; m_mask = 3'd7; e_take = 1'b0; e_lvl = '0;
         return;
      end
      edge_now = (req_level_i == 3'd7) && (m_prev != 3'd7);
      pend     = m_lat | edge_now;
      take     = boundary_i && (pend || (req_level_i != 0 && req_level_i != 7 && req_level_i > m_mask));
      svc      = pend ? 3'd7 : req_level_i;
      m_lat    = pend && !take;
      m_prev   = req_level_i;
      if (take) m_mask = svc;
      else if (sr_we_i) m_mask = sr_wdata_i[10:8];
      e_take = take;
      e_lvl  = take ? svc : 3'd0;
   endtask

   task automatic check(input string tag);
      n_cmp++;
      if (take_o !== e_take || take_level_o !== e_lvl || mask_o !== m_mask) begin
         n_bad++;
         $display("FAIL %s: take=%0b lvl=%0d mask=%0d expected take=%0b lvl=%0d mask=%0d",
                  tag, take_o, take_level_o, mask_o, e_take, e_lvl, m_mask);
      end
   endtask

   task automatic cyc(input logic [2:0] lvl, input logic strb, input logic we,
                      input logic [2:0] wm, input string tag);
      req_level_i = lvl; boundary_i = strb; sr_we_i = we; sr_wdata_i = sr_word(wm);
      model_step();
      @(posedge clk); #1;
      check(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      for (int i = 0; i < 3; i++) cyc(3'd7, 1'b1, 1'b1, 3'd0, "R1");
      rst_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd2024));
      #1;
      do_reset();
      // R3 / R4: mask lowered, level above mask taken, mask follows
      cyc(3'd0, 0, 1, 3'd2, "R8");
      cyc(3'd2, 1, 0, 3'd0, "R3");
      cyc(3'd5, 1, 0, 3'd0, "R3");
      cyc(3'd5, 1, 0, 3'd0, "R4");
      cyc(3'd4, 1, 0, 3'd0, "R3");
      // R2: no strobe, no take
      cyc(3'd0, 0, 1, 3'd0, "R8");
      cyc(3'd6, 0, 0, 3'd0, "R2");
      // R7: drop before strobe
      cyc(3'd0, 1, 0, 3'd0, "R7");
      // R8: write ignored when take happens
      cyc(3'd3, 1, 1, 3'd1, "R8");
      // R5/R9: rise to 7 between strobes, fall back, taken at mask 7
      cyc(3'd0, 0, 1, 3'd7, "R8");
      cyc(3'd7, 0, 0, 3'd0, "R9");
      cyc(3'd1, 0, 0, 3'd0, "R9");
      cyc(3'd0, 1, 0, 3'd0, "R5");
      // R6: held 7, not retaken even at low mask
      cyc(3'd7, 1, 0, 3'd0, "R5");
      cyc(3'd7, 0, 1, 3'd0, "R8");
      for (int i = 0; i < 4; i++) cyc(3'd7, 1, 0, 3'd0, "R6");
      // R1: latched edge cleared by reset
      cyc(3'd0, 0, 0, 3'd0, "R6");
      cyc(3'd7, 0, 0, 3'd0, "R9");
      do_reset();
      cyc(3'd0, 1, 0, 3'd0, "R1");
      // R10: level already 7 after reset counts as rise
      rst_n = 1'b0; cyc(3'd7, 0, 0, 3'd0, "R1"); rst_n = 1'b1;
      cyc(3'd7, 0, 0, 3'd0, "R10");
      cyc(3'd7, 1, 0, 3'd0, "R10");
      // random: sticky levels, sparse strobes
      begin
         logic [2:0] lv = 0;
         for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) lv = 3'($urandom_range(0, 7));
            cyc(lv, $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
                3'($urandom_range(0, 7)), "R3");
         end
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule